// File: doc/BRIEF.md
# Stereo PCM Serializer with Selectable Slot Width

This block takes parallel stereo PCM sample pairs and sends them out as a three-wire serial audio stream in I2S format: a word clock that tells left from right, a bit clock, and one data line. Every output transition is timed from a single master clock that runs at 384 times the sample rate. One audio frame therefore always lasts 384 master clocks, whichever slot width is in use.

Two settings are independent of each other. The sample precision is 16 or 20 bits. The slot per channel is 16, 24 or 32 bit clocks. Before a pair is serialized, a mute control and a step attenuator act on it. A new pair is taken from the upstream source through a ready/valid handshake, once per frame at the frame boundary. When no pair is offered at that boundary, the previous pair is sent again.

Top module: `i2s_slot_serializer`

## Requirements
- R1: The bit clock period is 384/(2·slot) master clocks: 12 for a 16-bit slot, 8 for a 24-bit slot and 6 for a 32-bit slot. The bit clock is low in the first half of each period and high in the second half. A frame holds 2·slot rising edges, and its first rise comes half a period after the frame starts.
- R2: The word clock is low for the left slot and high for the right slot. It changes only together with a falling bit-clock edge. It is low, together with the bit clock, in the first cycle of every frame.
- R3: Data changes only on falling bit-clock edges and is sent MSB first, one bit clock after the word-clock edge. During bit j of a frame (j ≥ 1) the line carries stream bit j−1. The stream is the left slot followed by the right slot, and slot position p carries sample bit (19−p). During bit 0 the line carries the last right-slot bit of the previous frame.
- R4: Slot positions at or past the precision (16 or 20) are sent as zero. With 16-bit precision only sample bits 19..4 are sent. When the precision exceeds the slot, only the top slot-width bits are sent.
- R5: `in_ready` is high for exactly one master clock, the last cycle of each 384-cycle frame. A pair offered with `in_valid` in that cycle is sent in the next frame.
- R6: If `in_valid` is low at the frame boundary, the previously accepted pair is sent again. Mute and attenuation are re-applied from the settings present at that boundary.
- R7: When `cfg_mute` is high at a frame boundary, every bit of both slots of the next frame is zero. Bit 0 still carries the last bit of the previous frame.
- R8: Each sample, taken as a signed 20-bit value, is arithmetically shifted right by `cfg_atten` (0..15) before precision masking.
- R9: Slot width and precision are taken at the frame boundary, and also during reset. Changing them within a frame has no effect on that frame.
- R10: During reset and in the cycle after it, the bit clock, the word clock, the data line and `in_ready` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, 384 × sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_slot | input | 2 | Slot width: 0 = 16, 1 = 24, 2 or 3 = 32 |
| cfg_prec_hi | input | 1 | 1 = 20-bit precision, 0 = 16-bit |
| cfg_mute | input | 1 | Force both channels to zero |
| cfg_atten | input | 4 | Attenuation as a right-shift count (about 6 dB per step) |
| in_valid | input | 1 | Upstream pair is offered |
| in_ready | output | 1 | Pair accepted in this cycle (frame boundary) |
| in_left | input | 20 | Left sample, signed, left-justified |
| in_right | input | 20 | Right sample, signed, left-justified |
| bclk_o | output | 1 | Serial bit clock |
| lrck_o | output | 1 | Word clock, low = left |
| sdata_o | output | 1 | Serial data |

## Verification
At the frame boundary, three things happen in one master clock: a new pair is loaded, the slot and precision settings are replaced, and the data line must still present the last bit of the outgoing frame under the old settings. The bench provokes this by sending frames back to back while it changes slot width, precision and mute between frames, and by changing the settings just after a boundary. For each frame it compares all 2·slot sampled bits with a stream computed arithmetically, where bit 0 is predicted from the previous frame's samples and settings.

// File: rtl/i2s_ser_pkg.sv
// Package: shared types and helpers for the stereo PCM serializer.
// Assumes one frame always spans a fixed number of master clocks.
package i2s_ser_pkg;
    localparam int CNT_W = 7;  // wide enough for 2*32 bit positions

    typedef enum logic [1:0] {
        SLOT_16  = 2'b00,
        SLOT_24  = 2'b01,
        SLOT_32  = 2'b10,
        SLOT_32B = 2'b11
    } slot_code_e;

    // Number of bit clocks in one channel slot for a slot code.
    function automatic logic [CNT_W-1:0] slot_len(slot_code_e code);
        case (code)
            SLOT_16: slot_len = CNT_W'(16);
            SLOT_24: slot_len = CNT_W'(24);
            default: slot_len = CNT_W'(32);
        endcase
    endfunction
endpackage

// File: rtl/i2s_bit_timer.sv
// Module: generates the bit clock, the word clock and the bit/frame strobes.
// Divides the master clock so that 2*slot bit periods fill MCLK_PER_FS
// master clocks. Assumes MCLK_PER_FS divides evenly by 32, 48 and 64, and
// that the slot code only changes on a frame_end edge.
module i2s_bit_timer
    import i2s_ser_pkg::*;
#(
    parameter int MCLK_PER_FS = 384
) (
    input  logic             clk,
    input  logic             rst_n,
    input  slot_code_e       slot_code,
    input  logic [CNT_W-1:0] slot_bits,
    output logic             bclk,
    output logic             lrck,
    output logic             bit_step,
    output logic             frame_end,
    output logic [CNT_W-1:0] bit_idx
);
    localparam int P16   = MCLK_PER_FS / 32;
    localparam int P24   = MCLK_PER_FS / 48;
    localparam int P32   = MCLK_PER_FS / 64;
    localparam int DIV_W = $clog2(P16 + 1);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] period;
    logic [CNT_W-1:0] bit_q;
    logic [CNT_W-1:0] last_bit;

    // Select the bit-clock period (in master clocks) for the active slot.
    always_comb begin
        case (slot_code)
            SLOT_16: period = DIV_W'(P16);
            SLOT_24: period = DIV_W'(P24);
            default: period = DIV_W'(P32);
        endcase
    end

    assign last_bit  = (slot_bits << 1) - CNT_W'(1);
    assign bit_step  = (div_q == period - DIV_W'(1));
    assign frame_end = bit_step && (bit_q == last_bit);
    assign bclk      = (div_q >= (period >> 1));
    assign lrck      = (bit_q >= slot_bits);
    assign bit_idx   = bit_q;

    // Advance the master-clock divider and the bit position within the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            bit_q <= '0;
        end else if (bit_step) begin
            div_q <= '0;
            bit_q <= frame_end ? '0 : bit_q + CNT_W'(1);
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/i2s_sample_cond.sv
// Module: applies attenuation, precision masking and mute to one sample.
// Purely combinational. The sample is signed and left-justified in SAMPLE_W
// bits. Low precision keeps only the top LOW_PREC bits.
module i2s_sample_cond #(
    parameter int SAMPLE_W = 20,
    parameter int LOW_PREC = 16,
    parameter int ATT_W    = 4
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                mute,
    input  logic [ATT_W-1:0]    atten,
    input  logic                prec_hi,
    output logic [SAMPLE_W-1:0] word
);
    localparam logic [SAMPLE_W-1:0] LOW_MASK =
        SAMPLE_W'((1 << (SAMPLE_W - LOW_PREC)) - 1);

    logic signed [SAMPLE_W-1:0] scaled;
    logic        [SAMPLE_W-1:0] masked;

    // Shift the signed sample right, then clear bits below the precision.
    always_comb begin
        scaled = $signed(sample) >>> atten;
        masked = prec_hi ? scaled : (scaled & ~LOW_MASK);
        word   = mute ? '0 : masked;
    end
endmodule

// File: rtl/i2s_frame_shifter.sv
// Module: holds the conditioned pair of the current frame and drives the
// data line. At each bit step the line takes stream bit bit_idx, which gives
// the one-bit-clock lag after the word clock. Assumes slot_bits and prec_hi
// only change on frame_end.
module i2s_frame_shifter
    import i2s_ser_pkg::*;
#(
    parameter int SAMPLE_W = 20,
    parameter int LOW_PREC = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_end,
    input  logic                bit_step,
    input  logic [CNT_W-1:0]    bit_idx,
    input  logic [CNT_W-1:0]    slot_bits,
    input  logic                prec_hi,
    input  logic [SAMPLE_W-1:0] next_l,
    input  logic [SAMPLE_W-1:0] next_r,
    output logic                sdata
);
    logic [SAMPLE_W-1:0] word_l;
    logic [SAMPLE_W-1:0] word_r;
    logic                in_right;
    logic [CNT_W-1:0]    pos;
    logic [CNT_W-1:0]    prec_len;
    logic [SAMPLE_W-1:0] aligned;
    logic                next_bit;

    // Pick the slot position addressed by bit_idx and the sample bit it carries.
    always_comb begin
        in_right = (bit_idx >= slot_bits);
        pos      = in_right ? bit_idx - slot_bits : bit_idx;
        prec_len = prec_hi ? CNT_W'(SAMPLE_W) : CNT_W'(LOW_PREC);
        aligned  = (in_right ? word_r : word_l) << pos;
        next_bit = (pos < prec_len) && aligned[SAMPLE_W-1];
    end

    // Load the pair at the frame boundary and register the data line per bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_l <= '0;
            word_r <= '0;
            sdata  <= 1'b0;
        end else begin
            if (frame_end) begin
                word_l <= next_l;
                word_r <= next_r;
            end
            if (bit_step) begin
                sdata <= next_bit;
            end
        end
    end
endmodule

// File: rtl/i2s_slot_serializer.sv
// Module: top of the stereo PCM serializer. It takes a pair through a
// ready/valid handshake at each frame boundary, keeps the raw pair so it can
// be repeated, and latches slot and precision per frame. Assumes clk is the
// 384 x fs master clock.
module i2s_slot_serializer
    import i2s_ser_pkg::*;
#(
    parameter int MCLK_PER_FS = 384,
    parameter int SAMPLE_W    = 20,
    parameter int LOW_PREC    = 16,
    parameter int ATT_W       = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cfg_slot,
    input  logic                cfg_prec_hi,
    input  logic                cfg_mute,
    input  logic [ATT_W-1:0]    cfg_atten,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    output logic                bclk_o,
    output logic                lrck_o,
    output logic                sdata_o
);
    slot_code_e                 slot_q;
    logic                       prec_q;
    logic [CNT_W-1:0]           slot_bits;
    logic                       bit_step;
    logic                       frame_end;
    logic [CNT_W-1:0]           bit_idx;
    logic [1:0][SAMPLE_W-1:0]   in_pair;
    logic [1:0][SAMPLE_W-1:0]   raw_q;
    logic [1:0][SAMPLE_W-1:0]   src;
    logic [1:0][SAMPLE_W-1:0]   cond;

    assign slot_bits = slot_len(slot_q);
    assign in_pair   = {in_right, in_left};
    assign in_ready  = frame_end;

    // Latch slot width and precision during reset and at each frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_end) begin
            slot_q <= slot_code_e'(cfg_slot);
            prec_q <= cfg_prec_hi;
        end
    end

    // Keep the last accepted raw pair for repetition when nothing is offered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= '0;
        end else if (frame_end && in_valid) begin
            raw_q <= in_pair;
        end
    end

    i2s_bit_timer #(
        .MCLK_PER_FS (MCLK_PER_FS)
    ) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_code (slot_q),
        .slot_bits (slot_bits),
        .bclk      (bclk_o),
        .lrck      (lrck_o),
        .bit_step  (bit_step),
        .frame_end (frame_end),
        .bit_idx   (bit_idx)
    );

    // One conditioner per channel: index 0 is left, index 1 is right.
    for (genvar c = 0; c < 2; c++) begin : g_ch
        assign src[c] = in_valid ? in_pair[c] : raw_q[c];
        i2s_sample_cond #(
            .SAMPLE_W (SAMPLE_W),
            .LOW_PREC (LOW_PREC),
            .ATT_W    (ATT_W)
        ) cond_i (
            .sample  (src[c]),
            .mute    (cfg_mute),
            .atten   (cfg_atten),
            .prec_hi (cfg_prec_hi),
            .word    (cond[c])
        );
    end

    i2s_frame_shifter #(
        .SAMPLE_W (SAMPLE_W),
        .LOW_PREC (LOW_PREC)
    ) shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (frame_end),
        .bit_step  (bit_step),
        .bit_idx   (bit_idx),
        .slot_bits (slot_bits),
        .prec_hi   (prec_q),
        .next_l    (cond[0]),
        .next_r    (cond[1]),
        .sdata     (sdata_o)
    );
endmodule

// File: rtl/i2s_slot_serializer_chk.sv
// Module: assertion checker bound to the serializer top. It watches only
// the ports. A small fall counter locates the first data bit of each frame.
module i2s_slot_serializer_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_mute,
    input logic in_ready,
    input logic bclk_o,
    input logic lrck_o,
    input logic sdata_o
);
    logic       bclk_d;
    logic       mute_pend;
    logic [1:0] fall_cnt;
    logic       bclk_fell;

    assign bclk_fell = bclk_d && !bclk_o;

    // Track the mute setting taken at each boundary and the bit-clock falls since.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_d    <= 1'b0;
            mute_pend <= 1'b0;
            fall_cnt  <= 2'd0;
        end else begin
            bclk_d <= bclk_o;
            if (in_ready) begin
                mute_pend <= cfg_mute;
                fall_cnt  <= 2'd0;
            end else if (bclk_fell && fall_cnt != 2'd2) begin
                fall_cnt <= fall_cnt + 2'd1;
            end
        end
    end

    AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> !in_ready);  // R5

    AST_FRAME_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> (!bclk_o && !lrck_o));  // R1

    AST_LRCK_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lrck_o) |-> $fell(bclk_o));  // R2

    AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata_o) |-> $fell(bclk_o));  // R3

    AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_pend && (fall_cnt == 2'd2 || (fall_cnt == 2'd1 && bclk_fell))) |-> !sdata_o);  // R7
endmodule

bind i2s_slot_serializer i2s_slot_serializer_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_mute (cfg_mute),
    .in_ready (in_ready),
    .bclk_o   (bclk_o),
    .lrck_o   (lrck_o),
    .sdata_o  (sdata_o)
);

// File: tb/i2s_slot_serializer_tb.sv
// Bench: sweeps slot width x precision x sample pattern, then mute, the
// attenuation steps, repetition, mid-frame setting changes and ready timing.
// Every frame's serial bits are predicted arithmetically.
module i2s_slot_serializer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_slot = 2'd2;
    logic        cfg_prec_hi = 1'b1;
    logic        cfg_mute = 1'b0;
    logic [3:0]  cfg_atten = 4'd0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [19:0] in_left = '0;
    logic [19:0] in_right = '0;
    logic        bclk_o, lrck_o, sdata_o;

    int n_checks = 0;
    int n_err = 0;
    logic [19:0] raw_l = '0, raw_r = '0;
    bit prev_bit = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    i2s_slot_serializer dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_slot(cfg_slot), .cfg_prec_hi(cfg_prec_hi),
        .cfg_mute(cfg_mute), .cfg_atten(cfg_atten), .in_valid(in_valid),
        .in_ready(in_ready), .in_left(in_left), .in_right(in_right),
        .bclk_o(bclk_o), .lrck_o(lrck_o), .sdata_o(sdata_o)
    );

    function automatic int slot_of(logic [1:0] code);
        return (code == 2'd0) ? 16 : (code == 2'd1) ? 24 : 32;
    endfunction

    function automatic logic [19:0] exp_word(logic [19:0] s, bit m, int a, bit p20);
        logic signed [19:0] t;
        t = $signed(s) >>> a;
        if (!p20) t[3:0] = 4'h0;
        if (m) t = '0;
        return t;
    endfunction

    function automatic bit stream_bit(logic [19:0] wl, logic [19:0] wr, int slot, bit p20, int k);
        int pos;
        logic [19:0] w;
        w   = (k >= slot) ? wr : wl;
        pos = (k >= slot) ? k - slot : k;
        if (pos >= (p20 ? 20 : 16)) return 1'b0;
        return w[19 - pos];
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Run one frame: optional send, optional mid-frame setting change, capture, compare.
    task automatic run_frame(input logic [19:0] l, input logic [19:0] r, input bit send,
                             input string tag, input int chg_slot, input int chg_prec);
        int slot, per, cyc, j;
        bit p20, tim_ok, prevb;
        logic [19:0] wl, wr;
        logic [63:0] got_d, got_lr, exp_d, exp_lr;
        if (send) begin
            in_left = l; in_right = r; in_valid = 1'b1;
        end
        while (!in_ready) @(negedge clk);
        slot = slot_of(cfg_slot);
        p20  = cfg_prec_hi;
        if (send) begin raw_l = l; raw_r = r; end
        wl = exp_word(raw_l, cfg_mute, int'(cfg_atten), p20);
        wr = exp_word(raw_r, cfg_mute, int'(cfg_atten), p20);
        @(posedge clk);
        in_valid <= 1'b0;
        if (chg_slot >= 0) cfg_slot <= 2'(chg_slot);
        if (chg_prec >= 0) cfg_prec_hi <= 1'(chg_prec);
        per = 384 / (2 * slot);
        got_d = '0; got_lr = '0; exp_d = '0; exp_lr = '0;
        tim_ok = 1'b1; prevb = 1'b0; cyc = 0; j = 0;
        while (j < 2 * slot && cyc < 400) begin
            @(negedge clk);
            if (bclk_o && !prevb) begin
                if (cyc != j * per + per / 2) tim_ok = 1'b0;
                got_d[j]  = sdata_o;
                got_lr[j] = lrck_o;
                j++;
            end
            prevb = bclk_o;
            cyc++;
        end
        exp_d[0] = prev_bit;
        for (int k = 1; k < 2 * slot; k++) exp_d[k] = stream_bit(wl, wr, slot, p20, k - 1);
        for (int k = 0; k < 2 * slot; k++) exp_lr[k] = (k >= slot);
        prev_bit = stream_bit(wl, wr, slot, p20, 2 * slot - 1);
        chk(tim_ok && j == 2 * slot, "R1 bit clock rises", 64'(j), 64'(2 * slot));
        chk(got_lr == exp_lr, "R2 word clock", got_lr, exp_lr);
        chk(got_d == exp_d, tag, got_d, exp_d);
    endtask

    initial begin : wdog
        repeat (200000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin : main
        logic [19:0] pl, pr;
        int n;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk({bclk_o, lrck_o, sdata_o, in_ready} == 4'b0, "R10 during reset",
            64'({bclk_o, lrck_o, sdata_o, in_ready}), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk({bclk_o, lrck_o, sdata_o, in_ready} == 4'b0, "R10 after reset",
            64'({bclk_o, lrck_o, sdata_o, in_ready}), 64'(0));

        // R3 R4: sweep of slot width x precision x pattern
        for (int sc = 0; sc < 3; sc++) begin
            for (int p = 0; p < 2; p++) begin
                for (int pat = 0; pat < 3; pat++) begin
                    cfg_slot = 2'(sc); cfg_prec_hi = 1'(p);
                    case (pat)
                        0: begin pl = 20'h80001; pr = 20'h7FFFE; end
                        1: begin pl = 20'hA5C3F; pr = 20'h12345; end
                        default: begin pl = 20'hFFFFF; pr = 20'h00018; end
                    endcase
                    run_frame(pl, pr, 1'b1, "R3 R4 stream", -1, -1);
                end
            end
        end

        // R6 repetition without a new pair
        cfg_slot = 2'd1; cfg_prec_hi = 1'b1;
        run_frame(20'h3C5A9, 20'hC3A56, 1'b1, "R6 load", -1, -1);
        run_frame('0, '0, 1'b0, "R6 repeat", -1, -1);

        // R7 mute on a new pair, on a repeated pair, then released
        cfg_mute = 1'b1;
        run_frame(20'h7F00F, 20'h8F0F1, 1'b1, "R7 mute new pair", -1, -1);
        run_frame('0, '0, 1'b0, "R7 mute repeated pair", -1, -1);
        cfg_mute = 1'b0;
        run_frame('0, '0, 1'b0, "R6 R7 unmuted repeat", -1, -1);

        // R8 every attenuation step, both precisions
        cfg_slot = 2'd2;
        for (int a = 0; a < 16; a++) begin
            cfg_atten = 4'(a);
            cfg_prec_hi = 1'(a % 2);
            run_frame(20'h81234, 20'h3FEDC, 1'b1, "R8 attenuation", -1, -1);
        end
        cfg_atten = 4'd0;

        // R9 change slot/precision just after the boundary: this frame keeps old values
        cfg_slot = 2'd2; cfg_prec_hi = 1'b1;
        run_frame(20'h9ABCD, 20'h6789F, 1'b1, "R9 old settings kept", 0, 0);
        run_frame(20'h9ABCD, 20'h6789F, 1'b1, "R9 new settings used", -1, -1);

        // R5 ready timing: one-cycle pulse, next one 383 negedges later
        while (!in_ready) @(negedge clk);
        pl = exp_word(raw_l, cfg_mute, int'(cfg_atten), cfg_prec_hi);
        pr = exp_word(raw_r, cfg_mute, int'(cfg_atten), cfg_prec_hi);
        prev_bit = stream_bit(pl, pr, slot_of(cfg_slot), cfg_prec_hi, 2 * slot_of(cfg_slot) - 1);
        @(posedge clk);
        @(negedge clk);
        chk(!in_ready, "R5 ready pulse width", 64'(in_ready), 64'(0));
        n = 0;
        while (!in_ready && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk(n == 383, "R5 ready interval", 64'(n), 64'(383));
        run_frame(20'h00F0F, 20'hF0F00, 1'b1, "R5 R3 load after interval", -1, -1);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule